// File: doc/BRIEF.md
# Two-Level Page Walk Sequencer

This block services a translation-buffer miss on a 4-Kbyte page. It takes a linear address, a flag telling whether the access that missed was a store, and the base of the top-level table. It then walks the two table levels in memory over a simple bus. For each entry it first does an unlocked test read. Only when a status flag needs setting does it follow with a locked read and write pair. When both levels have been handled, it fetches the line that holds the missing address and reports the physical frame number.

The bus is a single-master interface. A transfer starts with a one-cycle address strobe that carries the address, direction, lock and fill qualifiers. It ends on the ready input, and a line fill takes four readies. A directory or table entry whose present flag is clear stops the walk with a fault pulse. Such a walk does no write and no fill.

Top module: `pwalk_seq`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. The first address strobe comes in the cycle after acceptance.
- R2: The first read of a walk goes to `{base[31:12], lin[31:22], 2'b00}`. The second-level entry is read at `{dir[31:12], lin[21:12], 2'b00}`, where `dir` is the directory word returned. All directory accesses come before all table accesses, and both come before the fill.
- R3: Each entry is first read with `bus_lock` low and `bus_wr` low. This is a 4-byte probe read.
- R4: If the probe shows that no flag needs setting, the block makes no further access to that entry.
- R5: If the Accessed flag (bit 5) of an entry is 0, the block does a locked read of that entry. It then does a locked write of the value it read, with bit 5 set and every other bit unchanged.
- R6: On a store miss, the Dirty flag (bit 6) of the table entry is also set when clear. When bit 5 and bit 6 both need setting, one locked pair sets both. The directory entry's bit 6 is never changed.
- R7: `bus_lock` rises in the cycle of the locked read's strobe. It stays high up to and including the cycle in which the write's ready is sampled, and it is low in the cycle after.
- R8: After the walk, the block makes one strobe with `bus_fill` high at `{tbl[31:12], lin[11:5], 5'b0}`. It accepts four readies. `done` is high for exactly the cycle after the fourth ready, with `frame` equal to `tbl[31:12]`.
- R9: A probe that returns bit 0 (present) clear makes `fault` high for the following cycle. The walk then ends with no write and no fill.
- R10: The address strobe lasts one cycle and is not repeated before the transfer's final ready. `bus_addr` stays steady until that ready. A ready in the strobe cycle is ignored.
- R11: After reset, `req_ready` is high and `bus_ads`, `bus_lock`, `done` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Miss request |
| req_ready | output | 1 | Idle, request can be taken |
| req_lin | input | 32 | Linear address that missed |
| req_wr | input | 1 | The missing access is a store |
| tbl_base | input | 32 | Top-level table base, bits 31:12 used |
| bus_ads | output | 1 | Address strobe, one cycle per transfer |
| bus_addr | output | 32 | Transfer address |
| bus_wr | output | 1 | Transfer is a write |
| bus_lock | output | 1 | Locked sequence in progress |
| bus_fill | output | 1 | Transfer is a four-beat line fill |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ready |
| bus_rdy | input | 1 | Transfer ready |
| done | output | 1 | Walk and fill finished |
| fault | output | 1 | Walk stopped on a non-present entry |
| frame | output | 20 | Physical frame number, valid with done |

## Verification
A bus model answers each strobe after a random wait of zero to two cycles, starting no earlier than the cycle after the strobe. Every fill beat has its own random wait. All ready timing therefore comes from the model, and the bench checks transfer order, addresses, lock and write data as the strobes arrive, not at fixed times. The model samples `bus_lock` on every falling edge from the locked read's strobe through the write's ready. That catches a gap in the lock window in the cycle where it occurs. `done` and `fault` are sampled once per falling edge, and each must appear in the first cycle after the ready that ends the walk. After that cycle, the entry words are read back from the model's memory and compared with values computed from the initial flags.

// File: rtl/pwalk_seq.sv
module pwalk_seq #(
  parameter int FILL_BEATS = 4,
  parameter int A_POS = 5,
  parameter int D_POS = 6,
  parameter int P_POS = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_wr,
  input  logic [31:0] tbl_base,
  output logic        bus_ads,
  output logic [31:0] bus_addr,
  output logic        bus_wr,
  output logic        bus_lock,
  output logic        bus_fill,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_rdy,
  output logic        done,
  output logic        fault,
  output logic [19:0] frame
);
  localparam int BW = $clog2(FILL_BEATS + 1);
  localparam logic [31:0] A_MSK = 32'd1 << A_POS;
  localparam logic [31:0] D_MSK = 32'd1 << D_POS;

  typedef enum logic [2:0] {S_IDLE, S_ADS, S_WAIT, S_DONE, S_FAULT} st_t;
  typedef enum logic [2:0] {K_DPRB, K_DLRD, K_DLWR, K_TPRB, K_TLRD, K_TLWR, K_FILL} kind_t;

  st_t         st;
  kind_t       kind;
  logic [31:0] lin;
  logic        wacc;
  logic [19:0] base_hi, dir_hi, tbl_hi;
  logic [31:0] wdata;
  logic [BW-1:0] beats;

  logic on_dir, in_xfer, locked_op, need, present;
  logic [31:0] set_msk;

  assign on_dir    = (kind == K_DPRB) || (kind == K_DLRD) || (kind == K_DLWR);
  assign in_xfer   = (st == S_ADS) || (st == S_WAIT);
  assign locked_op = (kind == K_DLRD) || (kind == K_DLWR) || (kind == K_TLRD) || (kind == K_TLWR);
  assign set_msk   = on_dir ? A_MSK : (A_MSK | (wacc ? D_MSK : 32'd0));
  assign need      = ((bus_rdata & set_msk) != set_msk);
  assign present   = bus_rdata[P_POS];

  assign req_ready = (st == S_IDLE);
  assign bus_ads   = (st == S_ADS);
  assign bus_lock  = in_xfer && locked_op;
  assign bus_wr    = in_xfer && ((kind == K_DLWR) || (kind == K_TLWR));
  assign bus_fill  = in_xfer && (kind == K_FILL);
  assign bus_wdata = wdata;
  assign done      = (st == S_DONE);
  assign fault     = (st == S_FAULT);
  assign frame     = tbl_hi;

  always_comb begin
    if (on_dir)              bus_addr = {base_hi, lin[31:22], 2'b00};
    else if (kind == K_FILL) bus_addr = {tbl_hi, lin[11:5], 5'b0};
    else                     bus_addr = {dir_hi, lin[21:12], 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= K_DPRB;
      lin     <= '0;
      wacc    <= 1'b0;
      base_hi <= '0;
      dir_hi  <= '0;
      tbl_hi  <= '0;
      wdata   <= '0;
      beats   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin     <= req_lin;
          wacc    <= req_wr;
          base_hi <= tbl_base[31:12];
          kind    <= K_DPRB;
          st      <= S_ADS;
        end
        S_ADS: st <= S_WAIT;
        S_WAIT: if (bus_rdy) begin
          st <= S_ADS;
          case (kind)
            K_DPRB: begin
              dir_hi <= bus_rdata[31:12];
              if (!present)  st <= S_FAULT;
              else if (need) kind <= K_DLRD;
              else           kind <= K_TPRB;
            end
            K_DLRD: begin
              dir_hi <= bus_rdata[31:12];
              wdata  <= bus_rdata | set_msk;
              kind   <= K_DLWR;
            end
            K_DLWR: kind <= K_TPRB;
            K_TPRB: begin
              tbl_hi <= bus_rdata[31:12];
              beats  <= '0;
              if (!present)  st <= S_FAULT;
              else if (need) kind <= K_TLRD;
              else           kind <= K_FILL;
            end
            K_TLRD: begin
              tbl_hi <= bus_rdata[31:12];
              wdata  <= bus_rdata | set_msk;
              kind   <= K_TLWR;
            end
            K_TLWR: begin
              beats <= '0;
              kind  <= K_FILL;
            end
            default: begin
              beats <= beats + 1'b1;
              if (beats == BW'(FILL_BEATS - 1)) st <= S_DONE;
              else                              st <= S_WAIT;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwalk_seq_chk.sv
module pwalk_seq_chk #(
  parameter int FILL_BEATS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        bus_ads,
  input logic [31:0] bus_addr,
  input logic        bus_wr,
  input logic        bus_lock,
  input logic        bus_fill,
  input logic        bus_rdy,
  input logic        done,
  input logic        fault
);
  localparam int BW = $clog2(FILL_BEATS + 1);
  logic          pend;
  logic [BW-1:0] left;
  logic          last_rdy;

  assign last_rdy = pend && bus_rdy && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      left <= '0;
    end else if (bus_ads) begin
      pend <= 1'b1;
      left <= bus_fill ? BW'(FILL_BEATS - 1) : '0;
    end else if (pend && bus_rdy) begin
      if (left == '0) pend <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |-> !pend);
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ads || (pend && !last_rdy)) |=> $stable(bus_addr));
  assert_lock_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> (bus_ads && !bus_wr));
  assert_lock_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(bus_rdy && bus_wr));
  assert_write_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ads && bus_wr) |-> bus_lock);
  assert_done_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_rdy && bus_fill));
  assert_fault_after_probe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($past(bus_rdy && !bus_lock && !bus_wr && !bus_fill) && !done));
  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !req_ready);
endmodule

bind pwalk_seq pwalk_seq_chk #(.FILL_BEATS(FILL_BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_ads(bus_ads),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_lock(bus_lock), .bus_fill(bus_fill),
  .bus_rdy(bus_rdy), .done(done), .fault(fault)
);

// File: tb/sim_pwalk_seq.sv
module sim_pwalk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_wr = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        bus_ads, bus_wr, bus_lock, bus_fill;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_rdy = 1'b0;
  logic        done, fault;
  logic [19:0] frame;

  pwalk_seq u0 (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [31:0] mem [logic [31:0]];

  logic [31:0] lg_addr [8], lg_wd [8];
  logic        lg_wr [8], lg_lk [8], lg_fl [8];
  int          lg_n = 0;
  logic [31:0] ex_addr [8], ex_wd [8];
  logic        ex_wr [8], ex_lk [8], ex_fl [8];
  int          ex_n;
  logic        ex_fault;
  logic [19:0] ex_frame;
  logic [31:0] ex_dir, ex_tbl;

  logic        act = 0, pair = 0, cwr = 0, cfl = 0;
  logic [31:0] caddr = '0;
  int          dly = 0, beats = 0, lockerr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pair && !bus_lock) lockerr++;
      if (bus_ads) begin
        act = 1; caddr = bus_addr; cwr = bus_wr; cfl = bus_fill;
        beats = bus_fill ? 4 : 1;
        dly = int'($urandom % 3);
        if (bus_lock && !bus_wr) pair = 1;
        if (lg_n < 8) begin
          lg_addr[lg_n] = bus_addr; lg_wr[lg_n] = bus_wr; lg_lk[lg_n] = bus_lock;
          lg_fl[lg_n] = bus_fill; lg_wd[lg_n] = bus_wdata;
        end
        lg_n++;
        bus_rdy = 0;
      end else if (act) begin
        if (dly > 0) begin
          dly--; bus_rdy = 0;
        end else begin
          bus_rdy = 1;
          if (cwr) begin mem[caddr] = bus_wdata; pair = 0; end
          else if (!cfl) bus_rdata = mem.exists(caddr) ? mem[caddr] : 32'h0;
          else bus_rdata = $urandom;
          beats--;
          if (beats == 0) act = 0; else dly = int'($urandom % 3);
        end
      end else bus_rdy = 0;
    end
  end

  task automatic push(input logic [31:0] a, input logic w, input logic l,
                      input logic f, input logic [31:0] d);
    ex_addr[ex_n] = a; ex_wr[ex_n] = w; ex_lk[ex_n] = l; ex_fl[ex_n] = f; ex_wd[ex_n] = d;
    ex_n++;
  endtask

  task automatic build_exp(input logic [31:0] lin, input logic wr, input logic [31:0] base,
                           input logic [31:0] dir, input logic [31:0] tbl);
    logic [31:0] da, ta, m;
    ex_n = 0; ex_fault = 0; ex_frame = tbl[31:12]; ex_dir = dir; ex_tbl = tbl;
    da = {base[31:12], lin[31:22], 2'b00};
    push(da, 0, 0, 0, 0);
    if (!dir[0]) begin ex_fault = 1; return; end
    if (!dir[5]) begin
      push(da, 0, 1, 0, 0); ex_dir = dir | 32'h20; push(da, 1, 1, 0, ex_dir);
    end
    ta = {dir[31:12], lin[21:12], 2'b00};
    push(ta, 0, 0, 0, 0);
    if (!tbl[0]) begin ex_fault = 1; return; end
    m = 32'h20 | (wr ? 32'h40 : 32'h0);
    if ((tbl & m) != m) begin
      push(ta, 0, 1, 0, 0); ex_tbl = tbl | m; push(ta, 1, 1, 0, ex_tbl);
    end
    push({tbl[31:12], lin[11:5], 5'b0}, 0, 0, 1, 0);
  endtask

  task automatic walk(input logic [31:0] lin, input logic wr, input logic [31:0] base,
                      input logic [31:0] dir, input logic [31:0] tbl);
    logic [31:0] da, ta;
    int cyc;
    bit got_d, got_f;
    mem.delete();
    da = {base[31:12], lin[31:22], 2'b00};
    ta = {dir[31:12], lin[21:12], 2'b00};
    mem[da] = dir; mem[ta] = tbl;
    build_exp(lin, wr, base, dir, tbl);
    lg_n = 0; lockerr = 0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready before request", {31'b0, req_ready}, 1);
    req_lin = lin; req_wr = wr; tbl_base = base; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(bus_ads === 1'b1 && req_ready === 1'b0, "R1", "strobe after accept",
        {30'b0, bus_ads, req_ready}, 32'h2);
    got_d = 0; got_f = 0; cyc = 0;
    while (!got_d && !got_f && cyc < 300) begin
      @(negedge clk);
      got_d = done; got_f = fault; cyc++;
    end
    chk(cyc < 300, "R8", "walk finished", cyc, 300);
    chk(got_f == ex_fault, "R9", "fault outcome", {31'b0, got_f}, {31'b0, ex_fault});
    if (got_d && !ex_fault)
      chk(frame == ex_frame, "R8", "frame number", {12'b0, frame}, {12'b0, ex_frame});
    chk(lg_n == ex_n, "R2", "transfer count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n && i < 8; i++) begin
      chk(lg_addr[i] == ex_addr[i], "R2", "transfer address", lg_addr[i], ex_addr[i]);
      chk({lg_wr[i], lg_lk[i], lg_fl[i]} == {ex_wr[i], ex_lk[i], ex_fl[i]}, "R3",
          "transfer kind wr/lock/fill", {29'b0, lg_wr[i], lg_lk[i], lg_fl[i]},
          {29'b0, ex_wr[i], ex_lk[i], ex_fl[i]});
      if (ex_wr[i])
        chk(lg_wd[i] == ex_wd[i], "R5", "write data", lg_wd[i], ex_wd[i]);
    end
    chk(lockerr == 0, "R7", "lock gap cycles", lockerr, 0);
    chk(mem[da] == ex_dir, "R6", "directory word after walk", mem[da], ex_dir);
    chk(mem[ta] == ex_tbl, "R4", "table word after walk", mem[ta], ex_tbl);
    @(negedge clk);
    chk(done === 1'b0 && fault === 1'b0 && bus_lock === 1'b0, "R8", "single-cycle end pulse",
        {29'b0, done, fault, bus_lock}, 0);
  endtask

  function automatic logic [31:0] ent(input logic [19:0] fr, input logic d, input logic a,
                                      input logic p);
    logic [31:0] r;
    r = {fr, 12'h0} | ($urandom & 32'h0000_0F9E);
    r[6] = d; r[5] = a; r[0] = p;
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] base, lin;
    logic [19:0] tf, pf;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    chk(req_ready === 1 && bus_ads === 0 && bus_lock === 0 && done === 0 && fault === 0,
        "R11", "reset outputs", {27'b0, req_ready, bus_ads, bus_lock, done, fault}, 32'h10);
    rst_n = 1;
    for (int c = 0; c < 16; c++) begin
      base = {$urandom, 12'h0}; lin = $urandom;
      tf = base[31:12] ^ 20'h00401; pf = 20'(($urandom));
      walk(lin, c[3], base, ent(tf, c[2], c[1], 1), ent(pf, c[0], c[2], 1));
    end
    base = 32'h0001_2000;
    walk(32'hFFFF_FFFF, 1, base, ent(20'h00033, 0, 0, 0), ent(20'h5, 0, 0, 1));
    walk(32'h0000_0000, 1, base, ent(20'h00033, 0, 0, 1), ent(20'h5, 0, 0, 0));
    walk(32'h1234_5678, 1, base, ent(20'h00033, 0, 1, 1), ent(20'hABCDE, 1, 1, 1));
    for (int k = 0; k < 30; k++) begin
      base = {$urandom, 12'h0}; lin = $urandom;
      tf = base[31:12] ^ 20'h00800;
      walk(lin, $urandom % 2, base, ent(tf, $urandom % 2, $urandom % 2, ($urandom % 8) != 0),
           ent(20'($urandom), $urandom % 2, $urandom % 2, ($urandom % 8) != 0));
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule